// File: doc/BRIEF.md
# Page-Pair Translation Buffer with Associative Search

This block is a small fully associative translation buffer. It holds up to `ENTRIES` slots, 64 by default. Each slot ties one virtual page-pair tag to two physical page descriptors. The tag is a VPN2 value plus an address-space identifier. One descriptor serves the even page of the pair and the other serves the odd page. Software staging words come in as inputs: a high word carrying the tag, two low words carrying the descriptors, an index word and a replacement index. A command port selects one of four operations:

- an indexed read;
- an indexed write;
- a write to the supplied replacement slot;
- a probe, which searches every slot for the tag in the high word.

A combinational lookup port translates one virtual address. It reports the physical frame and flags two kinds of fault: an invalid page, and a store to a clean page.

The controller is a two-state machine. In `ST_IDLE` it accepts a command. A read or a write completes from `ST_IDLE` and leaves the machine in `ST_IDLE`. A probe takes the transition `ST_IDLE -> ST_PROBE`, and the search key is latched on that transition. In `ST_PROBE` the latched key is compared against all slots. The machine then takes the unconditional transition `ST_PROBE -> ST_IDLE` and publishes the result in index format.

Top module: `tlb_array`

## Requirements
- R1: After reset every field of every slot is zero, `busy`, `rd_valid` and `index_valid` are low, and `index_out` is zero.
- R2: Command code 2, accepted in `ST_IDLE`, writes the slot named by `index_in[5:0]`. The slot takes its VPN2 from `entryhi_in[39:13]` and its ASID from `entryhi_in[7:0]`. Each half takes PFN from bits 41:6, cache attribute from bits 5:3, dirty from bit 2 and valid from bit 1 of its low word (`entrylo0_in` for the even half, `entrylo1_in` for the odd half). The slot keeps one global bit, equal to `entrylo0_in[0] & entrylo1_in[0]`.
- R3: Command code 1 reads the slot named by `index_in[5:0]`. One clock edge after acceptance, `rd_valid` is high for one cycle. In the same cycle `entryhi_out` shows VPN2 at bits 39:13 and ASID at bits 7:0. `entrylo0_out` and `entrylo1_out` show the halves in the R2 layout, and both carry the slot's single global bit at bit 0. Every other bit is zero.
- R4: Command code 3 writes exactly as R2 does, but into the slot named by `random_in[5:0]`. `index_in` is ignored.
- R5: Command code 4 raises `busy` for exactly one cycle. `index_valid` then pulses together with a new `index_out`. On a hit, bit 31 is 0 and bits 5:0 hold the lowest-numbered matching slot. On a miss, bit 31 is 1 and bits 5:0 are 0. Bits 30:6 are always 0.
- R6: A slot matches when its VPN2 equals the key's VPN2 and, unless its global bit is set, its ASID equals the key's ASID. This rule holds for both the probe and the lookup.
- R7: The lookup port matches VPN2 `lk_vaddr[39:13]` and ASID `lk_asid` against all slots. It picks the lowest-numbered match. `lk_vaddr[12]` selects the odd (1) or even (0) half, which drives `lk_pfn` and `lk_cattr`. On a miss `lk_hit` and all other lookup outputs are 0.
- R8: `lk_fault_invalid` is high exactly when the lookup hits and the selected half's valid bit is clear.
- R9: `lk_fault_modify` is high exactly when `lk_store` is high, the lookup hits, and the selected half is valid but not dirty.
- R10: A command offered while `busy` is high is dropped. Command codes 0, 5, 6 and 7 change no slot and produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Command strobe |
| op_code | input | 3 | 1 read, 2 indexed write, 3 replacement write, 4 probe |
| index_in | input | 32 | Index staging word, slot in bits 5:0 |
| random_in | input | 6 | Replacement slot number |
| entryhi_in | input | 64 | Tag staging word |
| entrylo0_in | input | 64 | Even-half descriptor staging word |
| entrylo1_in | input | 64 | Odd-half descriptor staging word |
| busy | output | 1 | Probe in progress, commands dropped |
| rd_valid | output | 1 | Read data valid pulse |
| entryhi_out | output | 64 | Read tag |
| entrylo0_out | output | 64 | Read even-half descriptor |
| entrylo1_out | output | 64 | Read odd-half descriptor |
| index_valid | output | 1 | Probe result pulse |
| index_out | output | 32 | Probe result in index format |
| lk_vaddr | input | 40 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space identifier |
| lk_store | input | 1 | Lookup is a store |
| lk_hit | output | 1 | Lookup matched a slot |
| lk_pfn | output | 36 | Physical frame of the selected half |
| lk_cattr | output | 3 | Cache attribute of the selected half |
| lk_fault_invalid | output | 1 | Matched half is not valid |
| lk_fault_modify | output | 1 | Store to a clean valid half |

## Verification
The hardest situation to reach from the ports is a probe or lookup in which several slots match the same key. Only then does the lowest-number priority become visible, and only then do global and ASID-qualified slots compete for one key. The random stimulus draws VPN2 from eight values and ASID from four, so duplicate tags pile up across the 64 slots. Directed cases add a command issued during the probe's busy cycle, unused command codes, and half-pages that are invalid or clean.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VPN2_W  = 27;
    localparam int ASID_W  = 8;
    localparam int PFN_W   = 36;
    localparam int CATTR_W = 3;
    localparam int VA_W    = VPN2_W + 13;
    localparam int HALF_W  = PFN_W + CATTR_W + 2;

    typedef struct packed {
        logic [PFN_W-1:0]   pfn;
        logic [CATTR_W-1:0] cattr;
        logic               dirty;
        logic               valid;
    } tlb_half_t;

    typedef struct packed {
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
        logic              global_pg;
        tlb_half_t         even;
        tlb_half_t         odd;
    } tlb_entry_t;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_READ   = 3'd1,
        OP_WR_IDX = 3'd2,
        OP_WR_RND = 3'd3,
        OP_PROBE  = 3'd4
    } tlb_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_PROBE = 1'b1
    } tlb_state_e;

    // Descriptor word: frame at [HALF_W:6], attribute [5:3], dirty [2], valid [1], global [0]
    function automatic tlb_half_t half_from_word(input logic [63:0] w);
        half_from_word = tlb_half_t'(w[HALF_W:1]);
    endfunction

    function automatic logic [63:0] word_from_half(input tlb_half_t h, input logic g);
        word_from_half = {{(63 - HALF_W){1'b0}}, h, g};
    endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  tlb_entry_t                    wr_entry,
    output tlb_entry_t [ENTRIES-1:0]      slots
);
    tlb_entry_t [ENTRIES-1:0] slot_q;

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[gi] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(gi))) begin
                slot_q[gi] <= wr_entry;
            end
        end
    end

    assign slots = slot_q;
endmodule

// File: rtl/tlb_search.sv
module tlb_search
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  tlb_entry_t [ENTRIES-1:0] slots,
    input  logic [VPN2_W-1:0]        key_vpn2,
    input  logic [ASID_W-1:0]        key_asid,
    output logic                     hit,
    output logic [IDX_W-1:0]         hit_idx,
    output tlb_entry_t               hit_entry
);
    logic [ENTRIES-1:0] match;

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
        assign match[gi] = (slots[gi].vpn2 == key_vpn2) &&
                           (slots[gi].global_pg || (slots[gi].asid == key_asid));
    end

    always_comb begin
        hit     = |match;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
        hit_entry = slots[hit_idx];
    end
endmodule

// File: rtl/tlb_array.sv
module tlb_array
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_valid,
    input  logic [2:0]  op_code,
    input  logic [31:0] index_in,
    input  logic [5:0]  random_in,
    input  logic [63:0] entryhi_in,
    input  logic [63:0] entrylo0_in,
    input  logic [63:0] entrylo1_in,
    output logic        busy,
    output logic        rd_valid,
    output logic [63:0] entryhi_out,
    output logic [63:0] entrylo0_out,
    output logic [63:0] entrylo1_out,
    output logic        index_valid,
    output logic [31:0] index_out,
    input  logic [39:0] lk_vaddr,
    input  logic [7:0]  lk_asid,
    input  logic        lk_store,
    output logic        lk_hit,
    output logic [35:0] lk_pfn,
    output logic [2:0]  lk_cattr,
    output logic        lk_fault_invalid,
    output logic        lk_fault_modify
);
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int HI_PAD  = 64 - VA_W;
    localparam int MID_PAD = 13 - ASID_W;

    tlb_state_e state_q, state_d;

    logic                     accept;
    logic                     wr_en;
    logic [IDX_W-1:0]         wr_idx;
    tlb_entry_t               wr_entry;
    tlb_entry_t [ENTRIES-1:0] slots;

    logic [VPN2_W-1:0] key_vpn2_q;
    logic [ASID_W-1:0] key_asid_q;
    logic              pr_hit;
    logic [IDX_W-1:0]  pr_idx;
    tlb_entry_t        pr_entry;

    tlb_entry_t        rd_entry_q;
    logic              miss_q;
    logic [IDX_W-1:0]  res_idx_q;

    logic              lk_any;
    logic [IDX_W-1:0]  lk_idx;
    tlb_entry_t        lk_entry;
    tlb_half_t         lk_half;

    assign accept = op_valid && (state_q == ST_IDLE);
    assign wr_en  = accept && ((op_code == OP_WR_IDX) || (op_code == OP_WR_RND));
    assign wr_idx = (op_code == OP_WR_RND) ? random_in[IDX_W-1:0] : index_in[IDX_W-1:0];

    always_comb begin
        wr_entry.vpn2      = entryhi_in[VA_W-1:13];
        wr_entry.asid      = entryhi_in[ASID_W-1:0];
        wr_entry.global_pg = entrylo0_in[0] & entrylo1_in[0];
        wr_entry.even      = half_from_word(entrylo0_in);
        wr_entry.odd       = half_from_word(entrylo1_in);
    end

    tlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .slots    (slots)
    );

    tlb_search #(.ENTRIES(ENTRIES)) u_probe_search (
        .slots     (slots),
        .key_vpn2  (key_vpn2_q),
        .key_asid  (key_asid_q),
        .hit       (pr_hit),
        .hit_idx   (pr_idx),
        .hit_entry (pr_entry)
    );

    tlb_search #(.ENTRIES(ENTRIES)) u_lookup_search (
        .slots     (slots),
        .key_vpn2  (lk_vaddr[VA_W-1:13]),
        .key_asid  (lk_asid),
        .hit       (lk_any),
        .hit_idx   (lk_idx),
        .hit_entry (lk_entry)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (op_valid && (op_code == OP_PROBE)) state_d = ST_PROBE;
            ST_PROBE: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid    <= 1'b0;
            rd_entry_q  <= '0;
            index_valid <= 1'b0;
            miss_q      <= 1'b0;
            res_idx_q   <= '0;
            key_vpn2_q  <= '0;
            key_asid_q  <= '0;
        end else begin
            rd_valid    <= accept && (op_code == OP_READ);
            index_valid <= (state_q == ST_PROBE);
            if (accept && (op_code == OP_READ)) begin
                rd_entry_q <= slots[index_in[IDX_W-1:0]];
            end
            if (accept && (op_code == OP_PROBE)) begin
                key_vpn2_q <= entryhi_in[VA_W-1:13];
                key_asid_q <= entryhi_in[ASID_W-1:0];
            end
            if (state_q == ST_PROBE) begin
                miss_q    <= !pr_hit;
                res_idx_q <= pr_hit ? pr_idx : '0;
            end
        end
    end

    assign busy         = (state_q == ST_PROBE);
    assign index_out    = {miss_q, 25'b0, 6'(res_idx_q)};
    assign entryhi_out  = {{HI_PAD{1'b0}}, rd_entry_q.vpn2, {MID_PAD{1'b0}}, rd_entry_q.asid};
    assign entrylo0_out = word_from_half(rd_entry_q.even, rd_entry_q.global_pg);
    assign entrylo1_out = word_from_half(rd_entry_q.odd,  rd_entry_q.global_pg);

    assign lk_half          = lk_vaddr[12] ? lk_entry.odd : lk_entry.even;
    assign lk_hit           = lk_any;
    assign lk_pfn           = lk_any ? lk_half.pfn   : '0;
    assign lk_cattr         = lk_any ? lk_half.cattr : '0;
    assign lk_fault_invalid = lk_any && !lk_half.valid;
    assign lk_fault_modify  = lk_any && lk_store && lk_half.valid && !lk_half.dirty;
endmodule

module tlb_array_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [2:0]  op_code,
    input logic        busy,
    input logic        rd_valid,
    input logic        index_valid,
    input logic [31:0] index_out,
    input logic        lk_store,
    input logic        lk_hit,
    input logic        lk_fault_invalid,
    input logic        lk_fault_modify
);
    assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        index_out[30:6] == 25'b0);

    assert_miss_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (index_valid && index_out[31]) |-> (index_out[5:0] == 6'b0));

    assert_probe_enter_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 3'd4) && !busy) |=> busy);

    assert_probe_leave_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy && index_valid));

    assert_read_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 3'd1) && !busy) |=> rd_valid);

    assert_drop_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rd_valid);

    assert_idle_no_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !index_valid);

    assert_invalid_needs_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault_invalid |-> lk_hit);

    assert_modify_store_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault_modify |-> (lk_store && lk_hit && !lk_fault_invalid));
endmodule

bind tlb_array tlb_array_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .op_valid         (op_valid),
    .op_code          (op_code),
    .busy             (busy),
    .rd_valid         (rd_valid),
    .index_valid      (index_valid),
    .index_out        (index_out),
    .lk_store         (lk_store),
    .lk_hit           (lk_hit),
    .lk_fault_invalid (lk_fault_invalid),
    .lk_fault_modify  (lk_fault_modify)
);

// File: tb/tb_tlb_array.sv
module tb_tlb_array;
    localparam int CLK_PERIOD = 10;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [31:0] index_in = '0;
    logic [5:0]  random_in = '0;
    logic [63:0] entryhi_in = '0, entrylo0_in = '0, entrylo1_in = '0;
    logic        busy, rd_valid, index_valid;
    logic [63:0] entryhi_out, entrylo0_out, entrylo1_out;
    logic [31:0] index_out;
    logic [39:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_store = 1'b0;
    logic        lk_hit, lk_fault_invalid, lk_fault_modify;
    logic [35:0] lk_pfn;
    logic [2:0]  lk_cattr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tlb_array dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .index_in(index_in), .random_in(random_in), .entryhi_in(entryhi_in),
        .entrylo0_in(entrylo0_in), .entrylo1_in(entrylo1_in), .busy(busy),
        .rd_valid(rd_valid), .entryhi_out(entryhi_out), .entrylo0_out(entrylo0_out),
        .entrylo1_out(entrylo1_out), .index_valid(index_valid), .index_out(index_out),
        .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_store(lk_store), .lk_hit(lk_hit),
        .lk_pfn(lk_pfn), .lk_cattr(lk_cattr), .lk_fault_invalid(lk_fault_invalid),
        .lk_fault_modify(lk_fault_modify)
    );

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [26:0] m_vpn2 [N];
    logic [7:0]  m_asid [N];
    logic        m_g    [N];
    logic [40:0] m_h0   [N];
    logic [40:0] m_h1   [N];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_hi(input int i);
        return {24'b0, m_vpn2[i], 5'b0, m_asid[i]};
    endfunction

    function automatic logic [63:0] exp_lo(input logic [40:0] h, input logic g);
        return {22'b0, h, g};
    endfunction

    function automatic int model_match(input logic [26:0] v, input logic [7:0] a);
        for (int i = 0; i < N; i++)
            if (m_vpn2[i] == v && (m_g[i] || m_asid[i] == a)) return i;
        return -1;
    endfunction

    function automatic logic [31:0] model_probe(input logic [63:0] hi);
        int m;
        m = model_match(hi[39:13], hi[7:0]);
        if (m < 0) return 32'h8000_0000;
        return {26'b0, 6'(m)};
    endfunction

    task automatic issue(input logic [2:0] code, input int idx, input int rnd,
                         input logic [63:0] hi, input logic [63:0] lo0, input logic [63:0] lo1);
        @(negedge clk);
        op_valid    = 1'b1;
        op_code     = code;
        index_in    = 32'(idx);
        random_in   = 6'(rnd);
        entryhi_in  = hi;
        entrylo0_in = lo0;
        entrylo1_in = lo1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic model_write(input int i, input logic [63:0] hi, input logic [63:0] lo0, input logic [63:0] lo1);
        m_vpn2[i] = hi[39:13];
        m_asid[i] = hi[7:0];
        m_g[i]    = lo0[0] & lo1[0];
        m_h0[i]   = lo0[41:1];
        m_h1[i]   = lo1[41:1];
    endtask

    task automatic wr_idx(input int i, input logic [63:0] hi, input logic [63:0] lo0, input logic [63:0] lo1);
        issue(3'd2, i, (i + 17) % N, hi, lo0, lo1);
        model_write(i, hi, lo0, lo1);
    endtask

    task automatic rd_check(input int i, input string req);
        issue(3'd1, i, 0, '0, '0, '0);
        chk(rd_valid == 1'b1, {req, " rd_valid"}, 64'(rd_valid), 64'd1);
        chk(entryhi_out == exp_hi(i), {req, " entryhi_out"}, entryhi_out, exp_hi(i));
        chk(entrylo0_out == exp_lo(m_h0[i], m_g[i]), {req, " entrylo0_out"}, entrylo0_out, exp_lo(m_h0[i], m_g[i]));
        chk(entrylo1_out == exp_lo(m_h1[i], m_g[i]), {req, " entrylo1_out"}, entrylo1_out, exp_lo(m_h1[i], m_g[i]));
    endtask

    task automatic probe_check(input logic [63:0] hi, input string req);
        logic [31:0] e;
        e = model_probe(hi);
        issue(3'd4, 0, 0, hi, '0, '0);
        chk(busy == 1'b1, {req, " busy"}, 64'(busy), 64'd1);
        @(negedge clk);
        chk(index_valid == 1'b1 && busy == 1'b0, {req, " index_valid"}, 64'({index_valid, busy}), 64'b10);
        chk(index_out == e, {req, " index_out"}, 64'(index_out), 64'(e));
    endtask

    task automatic lookup_check(input logic [39:0] va, input logic [7:0] a, input bit st, input string req);
        int m;
        logic [40:0] h;
        logic eh, ei, em;
        logic [35:0] ep;
        logic [2:0] ec;
        @(negedge clk);
        lk_vaddr = va;
        lk_asid  = a;
        lk_store = st;
        #1;
        m  = model_match(va[39:13], a);
        eh = (m >= 0);
        h  = eh ? (va[12] ? m_h1[m] : m_h0[m]) : '0;
        ep = h[40:5];
        ec = h[4:2];
        ei = eh && !h[0];
        em = eh && st && h[0] && !h[1];
        chk(lk_hit == eh, {req, " lk_hit"}, 64'(lk_hit), 64'(eh));
        chk(lk_pfn == ep && lk_cattr == ec, {req, " lk_pfn/lk_cattr"}, {25'b0, lk_pfn, lk_cattr}, {25'b0, ep, ec});
        chk(lk_fault_invalid == ei, {req, " lk_fault_invalid"}, 64'(lk_fault_invalid), 64'(ei));
        chk(lk_fault_modify == em, {req, " lk_fault_modify"}, 64'(lk_fault_modify), 64'(em));
    endtask

    function automatic logic [63:0] mk_hi(input logic [26:0] v, input logic [7:0] a);
        return {24'b0, v, 5'b0, a};
    endfunction

    function automatic logic [63:0] mk_lo(input logic [35:0] pfn, input logic [2:0] c, input logic d, input logic v, input logic g);
        return {22'b0, pfn, c, d, v, g};
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        logic [63:0] hi, lo0, lo1;
        seed = $urandom(32'h5eed_1234);
        for (int i = 0; i < N; i++) begin
            m_vpn2[i] = '0; m_asid[i] = '0; m_g[i] = 1'b0; m_h0[i] = '0; m_h1[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(busy == 0 && rd_valid == 0 && index_valid == 0, "R1 control outputs", 64'({busy, rd_valid, index_valid}), 64'd0);
        chk(index_out == 32'd0, "R1 index_out", 64'(index_out), 64'd0);
        rd_check(7, "R1 cleared slot");
        lookup_check(40'h0_0000_1000, 8'd0, 1'b0, "R1 cleared slot lookup");

        // R2/R3: global is AND of the two halves
        wr_idx(3, mk_hi(27'd5, 8'd2), mk_lo(36'hA_BCDE_F012, 3'd3, 1'b1, 1'b1, 1'b1),
               mk_lo(36'h1_2345_6789, 3'd5, 1'b0, 1'b1, 1'b0));
        rd_check(3, "R2 R3 mixed global");
        wr_idx(4, mk_hi(27'd5, 8'd9), mk_lo(36'h0_0000_0044, 3'd2, 1'b1, 1'b1, 1'b1),
               mk_lo(36'h0_0000_0045, 3'd2, 1'b1, 1'b1, 1'b1) | 64'hFFFF_FC00_0000_0000);
        rd_check(4, "R2 R3 both global");

        // R6: ASID 7 misses slot 3 but hits global slot 4
        probe_check(mk_hi(27'd5, 8'd7), "R6 probe global");
        probe_check(mk_hi(27'd5, 8'd2), "R5 probe lowest hit");
        lookup_check({27'd5, 1'b1, 12'h123}, 8'd7, 1'b0, "R6 lookup global");
        probe_check(mk_hi(27'h7FF_FFFF, 8'd1), "R5 probe miss");

        // R4: replacement write ignores index_in
        hi = mk_hi(27'd77, 8'd1);
        lo0 = mk_lo(36'h0_0000_0777, 3'd1, 1'b1, 1'b1, 1'b0);
        lo1 = mk_lo(36'h0_0000_0778, 3'd1, 1'b1, 1'b1, 1'b0);
        issue(3'd3, 1, 9, hi, lo0, lo1);
        model_write(9, hi, lo0, lo1);
        rd_check(9, "R4 replacement slot");
        rd_check(1, "R4 index_in untouched");

        // R10: write offered during probe busy cycle is dropped
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd4; entryhi_in = mk_hi(27'd5, 8'd2);
        @(negedge clk);
        op_code = 3'd2; index_in = 32'd10;
        entryhi_in = mk_hi(27'd99, 8'd3); entrylo0_in = '1; entrylo1_in = '1;
        @(negedge clk);
        op_valid = 1'b0;
        chk(index_out == 32'd3, "R10 probe result during drop", 64'(index_out), 64'd3);
        rd_check(10, "R10 busy write dropped");

        // R10: unused codes
        issue(3'd6, 11, 11, mk_hi(27'd1, 8'd1), '1, '1);
        chk(rd_valid == 0 && busy == 0, "R10 unused code no pulse", 64'({rd_valid, busy}), 64'd0);
        rd_check(11, "R10 unused code no write");

        // R7/R8/R9: invalid even half, valid clean odd half
        wr_idx(20, mk_hi(27'd100, 8'd0), mk_lo(36'h0_0000_0AAA, 3'd4, 1'b1, 1'b0, 1'b0),
               mk_lo(36'h0_0000_0BBB, 3'd6, 1'b0, 1'b1, 1'b0));
        lookup_check({27'd100, 1'b0, 12'h000}, 8'd0, 1'b0, "R8 invalid half");
        lookup_check({27'd100, 1'b1, 12'hFFF}, 8'd0, 1'b1, "R9 store to clean");
        lookup_check({27'd100, 1'b1, 12'h010}, 8'd0, 1'b0, "R9 load to clean");
        lookup_check({27'd100, 1'b1, 12'h010}, 8'd1, 1'b1, "R7 asid mismatch");

        // Random mix over a narrow tag space
        for (int it = 0; it < 400; it++) begin
            int sel, idx;
            logic [26:0] v;
            logic [7:0] a;
            sel = int'($urandom % 5);
            idx = int'($urandom % N);
            v   = 27'($urandom % 8);
            a   = 8'($urandom % 4);
            hi  = {$urandom, $urandom};
            hi[39:13] = v; hi[7:0] = a;
            lo0 = {$urandom, $urandom};
            lo1 = {$urandom, $urandom};
            case (sel)
                0: wr_idx(idx, hi, lo0, lo1);
                1: begin
                    issue(3'd3, (idx + 5) % N, idx, hi, lo0, lo1);
                    model_write(idx, hi, lo0, lo1);
                end
                2: rd_check(idx, "R3 random read");
                3: probe_check(hi, "R5 R6 random probe");
                default: lookup_check({v, 1'($urandom), 12'($urandom)}, a, 1'($urandom), "R7 R8 R9 random lookup");
            endcase
        end

        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end
endmodule